// File: doc/BRIEF.md
# Hardware Cursor Clip and Bitmap Loader

This block prepares a small hardware cursor for a display pipeline. A request carries a signed screen position, the cursor bitmap's width and height, the active display size and an interlace flag. The block clips the cursor against all four screen edges. From that it works out the on-screen corner, the visible width and height, and the word offset and row stride at which an external fetcher must start reading the bitmap. Visible bitmap words then arrive on a valid/ready stream. Each word has its red and blue bytes exchanged and is written into cursor SRAM, and the write address jumps between banks as each bank fills.

Geometry is never applied to the live cursor registers directly. After the bitmap has been written, the new position and size are placed in a shadow copy and a one-shot commit is armed. The next frame-done pulse copies the shadow into the live registers, sets the enable and disarms the commit. A request that leaves nothing visible, or that has no bitmap, clears the enable at once and cancels any armed commit. A request whose visible size differs from the last armed size also clears the enable at once and forces a fresh bitmap load. If the cursor SRAM was powered down, the 256-entry transparency table is filled before the bitmap load.

The controller has four states. ST_IDLE waits for a request. It moves to ST_FILL when a load is needed and the SRAM is cold. It moves to ST_LOAD when a load is needed and the SRAM is warm. It moves to ST_ARM when only the position changed. ST_FILL moves to ST_LOAD after its 256th write. ST_LOAD moves to ST_ARM on its last accepted pixel word. ST_ARM always returns to ST_IDLE after one cycle.

Top module: `curs_clip_loader`

## Requirements
- R1: After reset, live_en is 0, live_pos and live_size are 0, busy and pix_ready are 0, and no SRAM write occurs.
- R2: When a bitmap is present and width and height are both nonzero, the request is rejected if either dimension exceeds 64 or both exceed 32. A rejection pulses req_rejected one cycle after acceptance, starts no load and leaves the live registers unchanged.
- R3: A negative coordinate gives screen coordinate 0 and a bitmap offset equal to its magnitude. The visible size shrinks by that offset and stops at zero. fetch_off equals y_offset × stride + x_offset.
- R4: When coordinate plus size exceeds the active size, the visible size becomes the active size minus the coordinate, or zero if that is negative.
- R5: With ilace high, fetch_stride is twice the bitmap width, and both the screen y and the visible height are halved (rounding down).
- R6: A request with no bitmap, or with a visible width or height of zero, clears live_en in the cycle after acceptance and cancels any armed commit. A later frame_done does not re-enable the cursor.
- R7: Positions are packed as {y[15:0], x[15:0]}. Sizes are packed as {height[15:0], width[15:0]}.
- R8: Armed geometry reaches live_pos, live_size and live_en=1 only in the cycle after a frame_done pulse, and the commit then disarms. A request that keeps the previous visible size and asks for no reload arms its geometry without any SRAM write.
- R9: Each bitmap word is written as {d[31:24], d[7:0], d[15:8], d[23:16]}.
- R10: Bitmap writes start at 0x0000 and step by one. When the low 8 bits wrap to zero, the address advances by a further 0xF00. When (address & 0x30FF) is then zero, it jumps to the second bank base 0x8000. Words 256, 1024 and 2047 therefore go to 0x1000, 0x8000 and 0xB0FF.
- R11: With sram_cold high at acceptance, 256 writes of 0x55555555 to addresses 0x4000 to 0x40FF come before the first bitmap word. Exactly visible width × height bitmap words follow.
- R12: An accepted request whose visible size differs from the last armed size clears live_en in the cycle after acceptance and forces a bitmap load, even when req_reload is 0.
- R13: busy is high from the first SRAM write to the last. Requests made while busy are ignored. A frame_done during a load does not commit the geometry being loaded.
- R14: When a hiding request and frame_done fall in the same cycle, the hide wins and live_en is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cursor request strobe, taken only when idle |
| req_reload | input | 1 | Request asks for the bitmap to be rewritten |
| req_bmp_ok | input | 1 | A bitmap is attached to the request |
| req_x | input | 16 | Signed cursor x position |
| req_y | input | 16 | Signed cursor y position |
| req_w | input | 7 | Bitmap width in pixels |
| req_h | input | 7 | Bitmap height in pixels |
| act_w | input | 16 | Active display width |
| act_h | input | 16 | Active display height |
| ilace | input | 1 | Interlaced output mode |
| sram_cold | input | 1 | Cursor SRAM was powered down |
| req_rejected | output | 1 | One-cycle pulse for an oversized request |
| pix_valid | input | 1 | Bitmap word valid |
| pix_data | input | 32 | ARGB bitmap word |
| pix_ready | output | 1 | Block accepts a bitmap word |
| sram_we | output | 1 | Cursor SRAM write strobe |
| sram_addr | output | 16 | Cursor SRAM write address |
| sram_wdata | output | 32 | Cursor SRAM write data |
| fetch_off | output | 24 | First bitmap word to fetch |
| fetch_stride | output | 8 | Bitmap row stride in words |
| frame_done | input | 1 | End-of-frame pulse |
| busy | output | 1 | SRAM writes in progress |
| live_en | output | 1 | Live cursor enable |
| live_pos | output | 32 | Live cursor position |
| live_size | output | 32 | Live cursor size |

## Verification
Two functions can act in the same cycle: the frame-done commit of armed geometry and the immediate disable from a newly accepted request. The bench first arms a position-only move. It then issues a request that leaves nothing visible and pulses frame_done in the same cycle. The result is correct if live_en reads 0 afterwards and a later frame_done leaves it at 0. The bench also pulses frame_done in the middle of a long load that followed a size change, and expects the cursor to stay disabled until a frame_done arrives after the load.

// File: rtl/curs_pkg.sv
package curs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_LOAD,
        ST_ARM
    } curs_state_e;

    // Red/blue channel exchange: byte 0 <-> byte 2
    function automatic logic [31:0] chan_swap(input logic [31:0] d);
        return {d[31:24], d[7:0], d[15:8], d[23:16]};
    endfunction
endpackage

// File: rtl/curs_clip.sv
module curs_clip #(
    parameter int CW = 16,
    parameter int DW = 7,
    parameter int OW = 24
) (
    input  logic [CW-1:0] pos_x,
    input  logic [CW-1:0] pos_y,
    input  logic [DW-1:0] dim_w,
    input  logic [DW-1:0] dim_h,
    input  logic [CW-1:0] act_w,
    input  logic [CW-1:0] act_h,
    input  logic          ilace,
    output logic [CW-1:0] scr_x,
    output logic [CW-1:0] scr_y,
    output logic [DW-1:0] vis_w,
    output logic [DW-1:0] vis_h,
    output logic [OW-1:0] fetch_off,
    output logic [DW:0]   stride
);
    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam bit IS_Y = (a == 1);
        logic [CW-1:0] pos, act, scr, scr_o;
        logic [DW-1:0] dim, vis, vis_o;
        logic [CW:0]   off, dim_e, pos_e, act_e;

        assign pos   = IS_Y ? pos_y : pos_x;
        assign act   = IS_Y ? act_h : act_w;
        assign dim   = IS_Y ? dim_h : dim_w;
        assign dim_e = (CW+1)'(dim);
        assign pos_e = {1'b0, pos};
        assign act_e = {1'b0, act};

        always_comb begin
            off = '0;
            scr = pos;
            vis = dim;
            if (pos[CW-1]) begin
                off = (CW+1)'(0) - {pos[CW-1], pos};
                scr = '0;
                vis = (off >= dim_e) ? '0 : DW'(dim_e - off);
            end else if ((pos_e + dim_e) > act_e) begin
                vis = (act_e > pos_e) ? DW'(act - pos) : '0;
            end
        end

        assign scr_o = (IS_Y && ilace) ? {1'b0, scr[CW-1:1]} : scr;
        assign vis_o = (IS_Y && ilace) ? {1'b0, vis[DW-1:1]} : vis;
    end

    assign scr_x     = g_axis[0].scr_o;
    assign scr_y     = g_axis[1].scr_o;
    assign vis_w     = g_axis[0].vis_o;
    assign vis_h     = g_axis[1].vis_o;
    assign stride    = ilace ? {dim_w, 1'b0} : {1'b0, dim_w};
    assign fetch_off = OW'(g_axis[1].off) * OW'(stride) + OW'(g_axis[0].off);
endmodule

// File: rtl/curs_addr_step.sv
module curs_addr_step #(
    parameter int          AW        = 16,
    parameter logic [15:0] RAM2_BASE = 16'h8000,
    parameter logic [15:0] BANK_SKIP = 16'h0F00,
    parameter logic [15:0] BANK_MASK = 16'h30FF
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] inc, skip;

    always_comb begin
        inc  = cur + AW'(1);
        skip = (inc[7:0] == 8'h00) ? inc + AW'(BANK_SKIP) : inc;
        nxt  = ((skip & AW'(BANK_MASK)) == '0) ? AW'(RAM2_BASE) : skip;
    end
endmodule

// File: rtl/curs_clip_loader.sv
module curs_clip_loader
    import curs_pkg::*;
#(
    parameter int          CW         = 16,
    parameter int          DW         = 7,
    parameter int          OW         = 24,
    parameter int          AW         = 16,
    parameter int          MAX_DIM    = 64,
    parameter int          HALF_DIM   = 32,
    parameter int          TRAN_WORDS = 256,
    parameter logic [15:0] RAM1_BASE  = 16'h0000,
    parameter logic [15:0] RAM2_BASE  = 16'h8000,
    parameter logic [15:0] TRAN_BASE  = 16'h4000,
    parameter logic [31:0] TRAN_FILL  = 32'h5555_5555
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_reload,
    input  logic          req_bmp_ok,
    input  logic [CW-1:0] req_x,
    input  logic [CW-1:0] req_y,
    input  logic [DW-1:0] req_w,
    input  logic [DW-1:0] req_h,
    input  logic [CW-1:0] act_w,
    input  logic [CW-1:0] act_h,
    input  logic          ilace,
    input  logic          sram_cold,
    output logic          req_rejected,
    input  logic          pix_valid,
    input  logic [31:0]   pix_data,
    output logic          pix_ready,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [31:0]   sram_wdata,
    output logic [OW-1:0] fetch_off,
    output logic [DW:0]   fetch_stride,
    input  logic          frame_done,
    output logic          busy,
    output logic          live_en,
    output logic [2*CW-1:0] live_pos,
    output logic [2*CW-1:0] live_size
);
    localparam int PW  = 2 * CW;
    localparam int LW  = 2 * DW;
    localparam int FCW = $clog2(TRAN_WORDS);

    curs_state_e   state, state_nx;
    logic [CW-1:0] scr_x, scr_y;
    logic [DW-1:0] vis_w, vis_h;
    logic [OW-1:0] clip_off;
    logic [DW:0]   clip_stride;
    logic [AW-1:0] load_addr, addr_nx;
    logic [FCW-1:0] fill_cnt;
    logic [LW-1:0] words_left;
    logic [PW-1:0] pend_pos, pend_size, hw_pos, hw_size, new_pos, new_size;
    logic          armed;
    logic          accept, too_big, rej, hide, go, size_chg, need_load;

    curs_clip #(.CW(CW), .DW(DW), .OW(OW)) clip_i (
        .pos_x(req_x), .pos_y(req_y), .dim_w(req_w), .dim_h(req_h),
        .act_w(act_w), .act_h(act_h), .ilace(ilace),
        .scr_x(scr_x), .scr_y(scr_y), .vis_w(vis_w), .vis_h(vis_h),
        .fetch_off(clip_off), .stride(clip_stride)
    );

    curs_addr_step #(.AW(AW), .RAM2_BASE(RAM2_BASE)) step_i (
        .cur(load_addr), .nxt(addr_nx)
    );

    // Request decode
    always_comb begin
        accept    = req_valid && (state == ST_IDLE);
        too_big   = (req_w > DW'(MAX_DIM)) || (req_h > DW'(MAX_DIM)) ||
                    ((req_w > DW'(HALF_DIM)) && (req_h > DW'(HALF_DIM)));
        rej       = req_bmp_ok && (req_w != '0) && (req_h != '0) && too_big;
        hide      = !req_bmp_ok || (vis_w == '0) || (vis_h == '0);
        go        = accept && !rej && !hide;
        new_pos   = {scr_y, scr_x};
        new_size  = {CW'(vis_h), CW'(vis_w)};
        size_chg  = (new_size != hw_size);
        need_load = req_reload || sram_cold || size_chg;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go) state_nx = need_load ? (sram_cold ? ST_FILL : ST_LOAD) : ST_ARM;
            ST_FILL: if (fill_cnt == FCW'(TRAN_WORDS - 1)) state_nx = ST_LOAD;
            ST_LOAD: if (pix_valid && (words_left == LW'(1))) state_nx = ST_ARM;
            ST_ARM:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs from state
    always_comb begin
        pix_ready  = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = load_addr;
        sram_wdata = chan_swap(pix_data);
        busy       = 1'b0;
        unique case (state)
            ST_FILL: begin
                busy       = 1'b1;
                sram_we    = 1'b1;
                sram_addr  = AW'(TRAN_BASE) + AW'(fill_cnt);
                sram_wdata = TRAN_FILL;
            end
            ST_LOAD: begin
                busy      = 1'b1;
                pix_ready = 1'b1;
                sram_we   = pix_valid;
            end
            default: ;
        endcase
    end

    // Datapath, shadow and live registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_rejected <= 1'b0;
            live_en      <= 1'b0;
            live_pos     <= '0;
            live_size    <= '0;
            armed        <= 1'b0;
            hw_pos       <= '0;
            hw_size      <= '0;
            pend_pos     <= '0;
            pend_size    <= '0;
            fetch_off    <= '0;
            fetch_stride <= '0;
            words_left   <= '0;
            fill_cnt     <= '0;
            load_addr    <= AW'(RAM1_BASE);
        end else begin
            req_rejected <= accept && rej;
            if (frame_done && armed) begin
                live_pos  <= hw_pos;
                live_size <= hw_size;
                live_en   <= 1'b1;
                armed     <= 1'b0;
            end
            if (accept && !rej && hide) begin
                live_en <= 1'b0;
                armed   <= 1'b0;
            end
            if (go) begin
                pend_pos     <= new_pos;
                pend_size    <= new_size;
                fetch_off    <= clip_off;
                fetch_stride <= clip_stride;
                words_left   <= LW'(vis_w) * LW'(vis_h);
                load_addr    <= AW'(RAM1_BASE);
                fill_cnt     <= '0;
                if (size_chg) begin
                    live_en <= 1'b0;
                    armed   <= 1'b0;
                end
            end
            if (state == ST_FILL) fill_cnt <= fill_cnt + FCW'(1);
            if ((state == ST_LOAD) && pix_valid) begin
                words_left <= words_left - LW'(1);
                load_addr  <= addr_nx;
            end
            if (state == ST_ARM) begin
                hw_pos  <= pend_pos;
                hw_size <= pend_size;
                armed   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/curs_clip_loader_chk.sv
module curs_clip_loader_chk #(
    parameter int AW = 16,
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_done,
    input logic          busy,
    input logic          sram_we,
    input logic          pix_ready,
    input logic [AW-1:0] sram_addr,
    input logic [31:0]   sram_wdata,
    input logic          req_rejected,
    input logic          live_en,
    input logic [PW-1:0] live_pos,
    input logic [PW-1:0] live_size
);
    assert_we_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> busy);
    assert_ready_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> busy);
    assert_reject_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_rejected |-> !busy);
    assert_enable_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live_en) |-> $past(frame_done));
    assert_pos_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_pos) |-> $past(frame_done));
    assert_size_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_size) |-> $past(frame_done));
    assert_fill_pattern_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && !pix_ready) |-> (sram_wdata == 32'h5555_5555));
    assert_bank_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && pix_ready) |-> (sram_addr[11:8] == 4'h0));
endmodule

bind curs_clip_loader curs_clip_loader_chk #(.AW(AW), .PW(2*CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .busy(busy),
    .sram_we(sram_we), .pix_ready(pix_ready), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .req_rejected(req_rejected), .live_en(live_en),
    .live_pos(live_pos), .live_size(live_size)
);

// File: tb/curs_clip_loader_tb_top.sv
module curs_clip_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_reload = 0, req_bmp_ok = 1, ilace = 0, sram_cold = 0;
    logic [15:0] req_x = 0, req_y = 0, act_w = 16'd640, act_h = 16'd480;
    logic [6:0]  req_w = 0, req_h = 0;
    logic        pix_valid = 1'b1, frame_done = 1'b0;
    logic [31:0] pix_data = '0;
    logic        req_rejected, pix_ready, sram_we, busy, live_en;
    logic [15:0] sram_addr;
    logic [31:0] sram_wdata, live_pos, live_size;
    logic [23:0] fetch_off;
    logic [7:0]  fetch_stride;

    int n_tests = 0, n_fail = 0;
    logic [15:0] a256, a1024, alast;

    always #5 clk = ~clk;

    curs_clip_loader dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reload(req_reload),
        .req_bmp_ok(req_bmp_ok), .req_x(req_x), .req_y(req_y), .req_w(req_w),
        .req_h(req_h), .act_w(act_w), .act_h(act_h), .ilace(ilace),
        .sram_cold(sram_cold), .req_rejected(req_rejected), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_ready(pix_ready), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .fetch_off(fetch_off),
        .fetch_stride(fetch_stride), .frame_done(frame_done), .busy(busy),
        .live_en(live_en), .live_pos(live_pos), .live_size(live_size)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int k);
        return 32'h1020_3040 + 32'(k) * 32'h0103_0507;
    endfunction

    function automatic logic [15:0] next_addr(input logic [15:0] a);
        logic [15:0] b;
        b = a + 16'd1;
        if (b[7:0] == 8'h00) b = b + 16'h0F00;
        if ((b & 16'h30FF) == 16'h0000) b = 16'h8000;
        return b;
    endfunction

    task automatic send_req(input int x, input int y, input int w, input int h,
                            input bit reload, input bit bmp, input bit cold, input bit fd);
        @(negedge clk);
        req_x = 16'(x); req_y = 16'(y); req_w = 7'(w); req_h = 7'(h);
        req_reload = reload; req_bmp_ok = bmp; sram_cold = cold;
        req_valid = 1'b1; frame_done = fd;
        @(negedge clk);
        req_valid = 1'b0; frame_done = 1'b0;
        #1;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        #1;
    endtask

    // Follows one load from the negedge after acceptance to the end of busy
    task automatic drain(input bit exp_fill, input int exp_words, input int fd_at,
                         input bit mid, input string tag);
        int nf = 0, nl = 0;
        logic [15:0] ea = 16'h0000;
        logic [31:0] bad_aa = 0, bad_ae = 0, bad_da = 0, bad_de = 0, bad_fa = 0, bad_fe = 0;
        bit ba = 0, bd = 0, bfl = 0;
        while (busy) begin
            pix_data = word_of(nl);
            #1;
            frame_done = pix_ready && (nl == fd_at);
            req_valid  = mid && pix_ready && (nl == 5);
            if (req_valid) begin
                req_x = 16'd99; req_y = 16'd99; req_w = 7'd8; req_h = 7'd8;
            end
            if (sram_we) begin
                if (exp_fill && nf < 256) begin
                    if (!bfl && (sram_addr !== 16'h4000 + 16'(nf) || sram_wdata !== 32'h5555_5555)) begin
                        bfl = 1; bad_fa = {sram_addr, sram_wdata[15:0]};
                        bad_fe = {16'h4000 + 16'(nf), 16'h5555};
                    end
                    nf++;
                end else begin
                    if (!ba && sram_addr !== ea) begin ba = 1; bad_aa = 32'(sram_addr); bad_ae = 32'(ea); end
                    if (!bd && sram_wdata !== {word_of(nl)[31:24], word_of(nl)[7:0],
                                               word_of(nl)[15:8], word_of(nl)[23:16]}) begin
                        bd = 1; bad_da = sram_wdata;
                        bad_de = {word_of(nl)[31:24], word_of(nl)[7:0], word_of(nl)[15:8], word_of(nl)[23:16]};
                    end
                    if (nl == 256)  a256  = sram_addr;
                    if (nl == 1024) a1024 = sram_addr;
                    alast = sram_addr;
                    ea = next_addr(ea);
                    nl++;
                end
            end
            @(negedge clk);
            frame_done = 1'b0;
            req_valid  = 1'b0;
        end
        #1;
        chk({"R11 transparency writes ", tag}, 32'(nf), exp_fill ? 32'd256 : 32'd0);
        chk({"R11 transparency content ", tag}, bad_fa, bad_fe);
        chk({"R11 bitmap word count ", tag}, 32'(nl), 32'(exp_words));
        chk({"R10 write address ", tag}, bad_aa, bad_ae);
        chk({"R9 channel swap ", tag}, bad_da, bad_de);
    endtask

    task automatic t_reset();
        chk("R1 reset live_en", 32'(live_en), 0);
        chk("R1 reset live_pos", live_pos, 0);
        chk("R1 reset live_size", live_size, 0);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset pix_ready", 32'(pix_ready), 0);
        chk("R1 reset sram_we", 32'(sram_we), 0);
    endtask

    task automatic t_first_load();
        send_req(10, 20, 8, 4, 1, 1, 1, 0);
        chk("R13 busy at fill start", 32'(busy), 1);
        chk("R3 fetch_off plain", 32'(fetch_off), 0);
        chk("R3 stride plain", 32'(fetch_stride), 8);
        drain(1, 32, -1, 0, "first");
        chk("R8 not live before frame", 32'(live_en), 0);
        frame_pulse();
        chk("R8 enable after frame", 32'(live_en), 1);
        chk("R7 packed position", live_pos, 32'h0014_000A);
        chk("R7 packed size", live_size, 32'h0004_0008);
    endtask

    task automatic t_big_midframe();
        send_req(0, 0, 64, 32, 0, 1, 0, 0);
        chk("R12 size change disables now", 32'(live_en), 0);
        chk("R12 size change forces load", 32'(busy), 1);
        drain(0, 2048, 100, 0, "64x32");
        chk("R10 word 256 address", 32'(a256), 32'h1000);
        chk("R10 word 1024 address", 32'(a1024), 32'h8000);
        chk("R10 last word address", 32'(alast), 32'hB0FF);
        chk("R13 frame_done mid-load no commit", 32'(live_en), 0);
        frame_pulse();
        chk("R8 commit 64x32 en", 32'(live_en), 1);
        chk("R2 64x32 accepted size", live_size, 32'h0020_0040);
    endtask

    task automatic t_neg_clip();
        send_req(-3, -2, 64, 32, 0, 1, 0, 0);
        chk("R3 offset into bitmap", 32'(fetch_off), 131);
        chk("R3 stride", 32'(fetch_stride), 64);
        drain(0, 1830, -1, 0, "negclip");
        frame_pulse();
        chk("R3 screen pos clamps to 0", live_pos, 32'h0000_0000);
        chk("R3 size shrinks", live_size, 32'h001E_003D);
    endtask

    task automatic t_edge_clip_busy_req();
        send_req(630, 470, 16, 16, 1, 1, 0, 0);
        chk("R4 no offset at far edge", 32'(fetch_off), 0);
        drain(0, 100, -1, 1, "edge");
        frame_pulse();
        chk("R4 far edge position", live_pos, 32'h01D6_0276);
        chk("R4 far edge size", live_size, 32'h000A_000A);
        chk("R13 request while busy ignored", 32'(fetch_stride), 16);
    endtask

    task automatic t_interlace();
        ilace = 1'b1;
        send_req(5, 9, 8, 6, 1, 1, 0, 0);
        chk("R5 stride doubles", 32'(fetch_stride), 16);
        drain(0, 24, -1, 0, "ilace");
        frame_pulse();
        chk("R5 y halved", live_pos, 32'h0004_0005);
        chk("R5 height halved", live_size, 32'h0003_0008);
        send_req(7, 11, 8, 6, 0, 1, 0, 0);
        chk("R8 move without load not busy", 32'(busy), 0);
        chk("R8 move without load no write", 32'(sram_we), 0);
        chk("R8 move keeps cursor on", 32'(live_en), 1);
        frame_pulse();
        chk("R8 move commits", live_pos, 32'h0005_0007);
        ilace = 1'b0;
    endtask

    task automatic t_reject();
        send_req(0, 0, 65, 1, 1, 1, 0, 0);
        chk("R2 width 65 rejected", 32'(req_rejected), 1);
        chk("R2 reject no load", 32'(busy), 0);
        send_req(0, 0, 33, 33, 1, 1, 0, 0);
        chk("R2 33x33 rejected", 32'(req_rejected), 1);
        chk("R2 reject keeps live", 32'(live_en), 1);
        send_req(0, 0, 32, 64, 1, 1, 0, 0);
        chk("R2 32x64 accepted", 32'(req_rejected), 0);
        drain(0, 2048, -1, 0, "32x64");
        frame_pulse();
        chk("R2 32x64 size", live_size, 32'h0040_0020);
    endtask

    task automatic t_hide();
        send_req(1, 1, 32, 64, 0, 1, 0, 0);
        send_req(-20, 1, 16, 8, 0, 1, 0, 0);
        chk("R6 zero width hides", 32'(live_en), 0);
        chk("R3 floor at zero no load", 32'(busy), 0);
        frame_pulse();
        chk("R6 armed move cancelled", 32'(live_en), 0);
        send_req(2, 2, 32, 64, 0, 1, 0, 0);
        send_req(0, 0, 8, 8, 0, 0, 0, 1);
        chk("R14 hide beats same-cycle frame_done", 32'(live_en), 0);
        frame_pulse();
        chk("R6 no bitmap stays off", 32'(live_en), 0);
        send_req(640, 0, 8, 8, 0, 1, 0, 0);
        chk("R4 past edge hidden no load", 32'(busy), 0);
        frame_pulse();
        chk("R4 past edge stays off", 32'(live_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_first_load();
        t_big_midframe();
        t_neg_clip();
        t_edge_clip_busy_req();
        t_interlace();
        t_reject();
        t_hide();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R13 watchdog actual=busy_or_hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule